// File: doc/BRIEF.md
# 40-bit Multiply-Accumulate Unit

This block is a two-stage multiply-accumulate datapath. It multiplies two 16-bit operands and combines the product with a 40-bit accumulator. The accumulator has an 8-bit guard extension above a 32-bit body. Each operand can be read as signed or unsigned. The product can be doubled (fractional mode), negated, added to or subtracted from the accumulator, or loaded into it in place of the old value. The result can then be rounded to the high word and clipped to the 32-bit signed range.

An operation is offered with `in_valid`, together with its operands and control bits. Its multiply stage is registered on the first clock edge. The accumulate stage updates the accumulator and the status flags on the second edge, when `out_valid` rises. Operations may follow each other on every cycle. Each one sees the accumulator that its predecessor has written. The sticky saturation flag stays set until the `sl_clear` input is asserted.

Top module: `mac40_unit`

## Requirements
- R1: After reset the accumulator is zero, all six flags are 0 and `out_valid` is 0.
- R2: `mode` bit 1 marks `op_a` as signed and bit 0 marks `op_b` as signed. The product takes its true numeric value extended to 40 bits. With `accumulate`=1 the product is combined with the accumulator; with `accumulate`=0 it replaces the accumulator.
- R3: With `round_en`=1, 0000_8000h is added to the combined result and bits 15..0 of the result are then forced to zero.
- R4: With `ms_mode`=1, a result whose bits 39..31 are not all equal becomes 00_7FFF_FFFFh if bit 39 is 0, and FF_8000_0000h if bit 39 is 1. Clipping is applied after rounding.
- R5: With `mp_mode`=1 and both operands signed (`mode`=11), the product is doubled. When either operand is unsigned, `mp_mode` has no effect.
- R6: With `mp_mode`=1, `mode`=11 and both operands equal to 8000h, the product becomes 00_7FFF_FFFFh and counts as a saturation event.
- R7: `negate`=1 negates the product. `subtract`=1 subtracts the product from the accumulator. With both set, the two negations cancel.
- R8: `flag_sl` sets whenever a saturation event of R4 or R6 occurs. It stays set until `sl_clear` is high at a clock edge. A saturation event in the same cycle as `sl_clear` leaves the flag set.
- R9: The result of an operation appears two clock edges after its `in_valid` edge, with `out_valid` high for one cycle. Without an operation, the accumulator and flags N, Z, C, SV, E hold their values.
- R10: `flag_n` is bit 39 of the result and `flag_z` is set when all 40 bits are zero. `flag_c` is the carry out of bit 39 of the sum accumulator + product, or of accumulator + inverted product + 1 when subtracting, ORed with the carry of the rounding add. `flag_sv` is set when the signed 40-bit value overflows in either of those adds.
- R11: `flag_e` is set when bits 39..31 of the result are not all equal, that is, when the result lies outside the 32-bit signed range.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation offered this cycle |
| op_a | input | 16 | First operand |
| op_b | input | 16 | Second operand |
| mode | input | 2 | Operand signedness: bit 1 for op_a, bit 0 for op_b (1 = signed) |
| negate | input | 1 | Negate the product |
| subtract | input | 1 | Subtract the product from the accumulator |
| accumulate | input | 1 | 1: combine with the accumulator, 0: load the product |
| round_en | input | 1 | Round to the high word |
| mp_mode | input | 1 | Double signed-by-signed products |
| ms_mode | input | 1 | Clip the result to the 32-bit signed range |
| sl_clear | input | 1 | Clear the sticky saturation flag |
| out_valid | output | 1 | Accumulator and flags updated this cycle |
| acc | output | 40 | Accumulator |
| flag_n | output | 1 | Negative |
| flag_z | output | 1 | Zero |
| flag_c | output | 1 | Carry |
| flag_sv | output | 1 | 40-bit overflow |
| flag_e | output | 1 | Result outside the 32-bit range |
| flag_sl | output | 1 | Sticky saturation |

## Verification
The bench builds the block with its default 16-bit operands and 8-bit guard. At that size a 40-bit overflow takes a few hundred doubled near-full-scale accumulations, so the bench drives it directly without clipping. The 8000h by 8000h corner and every mix of signedness can be reached with chosen operand values. A long run of random operations, with random mode, rounding, clipping and clear bits, is checked against an integer model on every cycle.

// File: rtl/mac40_pkg.sv
package mac40_pkg;

  // operand signedness: bit 1 = op_a signed, bit 0 = op_b signed
  typedef enum logic [1:0] {
    MUL_UU = 2'b00,
    MUL_US = 2'b01,
    MUL_SU = 2'b10,
    MUL_SS = 2'b11
  } mul_mode_e;

  // controls that travel with a product into the accumulate stage
  typedef struct packed {
    logic subtract;
    logic accumulate;
    logic round_en;
    logic ms;
  } mac_ctrl_t;

endpackage

// File: rtl/mac40_mul.sv
module mac40_mul
  import mac40_pkg::*;
#(
  parameter int OP_W    = 16,
  parameter int GUARD_W = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         in_valid,
  input  logic [OP_W-1:0]              op_a,
  input  logic [OP_W-1:0]              op_b,
  input  logic [1:0]                   mode,
  input  logic                         mp_mode,
  input  logic                         negate,
  output logic                         valid_q,
  output logic [2*OP_W+GUARD_W-1:0]    prod_q,
  output logic                         prod_sat_q
);

  localparam int PROD_W = 2 * OP_W;
  localparam int ACC_W  = PROD_W + GUARD_W;
  localparam int XW     = PROD_W + 2;
  localparam logic [ACC_W-1:0] POS32  = {{(GUARD_W+1){1'b0}}, {(PROD_W-1){1'b1}}};
  localparam logic [OP_W-1:0]  OP_MIN = {1'b1, {(OP_W-1){1'b0}}};

  // true-value product, optional doubling with its one saturating corner, optional negation
  function automatic logic [ACC_W-1:0] form_product(
    input  logic [OP_W-1:0] a,
    input  logic [OP_W-1:0] b,
    input  logic            a_s,
    input  logic            b_s,
    input  logic            mp,
    input  logic            neg,
    output logic            sat
  );
    logic signed [OP_W:0]  ea;
    logic signed [OP_W:0]  eb;
    logic signed [XW-1:0]  p;
    logic [ACC_W-1:0]      x;
    ea  = $signed({a_s & a[OP_W-1], a});
    eb  = $signed({b_s & b[OP_W-1], b});
    p   = ea * eb;
    x   = {{(ACC_W-XW){p[XW-1]}}, p};
    sat = 1'b0;
    if (a_s && b_s && mp) begin
      if (a == OP_MIN && b == OP_MIN) begin
        x   = POS32;
        sat = 1'b1;
      end else begin
        x = x << 1;
      end
    end
    if (neg) x = -x;
    return x;
  endfunction

  logic [ACC_W-1:0] prod_d;
  logic             sat_d;

  always_comb prod_d = form_product(op_a, op_b, mode[1], mode[0], mp_mode, negate, sat_d);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q    <= 1'b0;
      prod_q     <= '0;
      prod_sat_q <= 1'b0;
    end else begin
      valid_q <= in_valid;
      if (in_valid) begin
        prod_q     <= prod_d;
        prod_sat_q <= sat_d;
      end
    end
  end

  // R6: the doubled minimum-by-minimum product is clipped and flagged
  p_mp_min_sat_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mode == MUL_SS && mp_mode && !negate && op_a == OP_MIN && op_b == OP_MIN)
    |=> (prod_q == POS32 && prod_sat_q));

endmodule

// File: rtl/mac40_acc.sv
module mac40_acc
  import mac40_pkg::*;
#(
  parameter int OP_W    = 16,
  parameter int GUARD_W = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         st_valid,
  input  logic [2*OP_W+GUARD_W-1:0]    prod,
  input  logic                         prod_sat,
  input  mac_ctrl_t                    ctrl,
  input  logic                         sl_clear,
  output logic                         out_valid,
  output logic [2*OP_W+GUARD_W-1:0]    acc_q,
  output logic                         n_q,
  output logic                         z_q,
  output logic                         c_q,
  output logic                         sv_q,
  output logic                         e_q,
  output logic                         sl_q
);

  localparam int PROD_W = 2 * OP_W;
  localparam int ACC_W  = PROD_W + GUARD_W;
  localparam int MSB    = ACC_W - 1;
  localparam int TOP_LO = PROD_W - 1;   // lowest of the guard+sign bits checked for range
  localparam logic [ACC_W-1:0] POS32    = {{(GUARD_W+1){1'b0}}, {(PROD_W-1){1'b1}}};
  localparam logic [ACC_W-1:0] NEG32    = {{(GUARD_W+1){1'b1}}, {(PROD_W-1){1'b0}}};
  localparam logic [ACC_W:0]   ROUND_K  = (ACC_W+1)'(1) << (OP_W - 1);
  localparam logic [ACC_W-1:0] LOW_MASK = {{(ACC_W-OP_W){1'b0}}, {OP_W{1'b1}}};

  function automatic logic out_of_32(input logic [ACC_W-1:0] v);
    return !((&v[MSB:TOP_LO]) || !(|v[MSB:TOP_LO]));
  endfunction

  // named internal events
  logic [ACC_W-1:0] base, addend, rounded, result;
  logic [ACC_W:0]   sum1, rsum;
  logic             v_add, v_rnd, carry, clip, sat_event;

  always_comb begin
    base    = ctrl.accumulate ? acc_q : '0;
    addend  = ctrl.subtract ? ~prod : prod;
    sum1    = {1'b0, base} + {1'b0, addend} + (ACC_W+1)'(ctrl.subtract);
    v_add   = (base[MSB] == addend[MSB]) && (sum1[MSB] != base[MSB]);
    rsum    = {1'b0, sum1[MSB:0]} + (ctrl.round_en ? ROUND_K : '0);
    v_rnd   = !sum1[MSB] && rsum[MSB];
    carry   = sum1[ACC_W] | rsum[ACC_W];
    rounded = ctrl.round_en ? (rsum[MSB:0] & ~LOW_MASK) : rsum[MSB:0];
    clip    = ctrl.ms && out_of_32(rounded);
    result  = clip ? (rounded[MSB] ? NEG32 : POS32) : rounded;
    sat_event = st_valid && (clip || prod_sat);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      acc_q     <= '0;
      n_q       <= 1'b0;
      z_q       <= 1'b0;
      c_q       <= 1'b0;
      sv_q      <= 1'b0;
      e_q       <= 1'b0;
      sl_q      <= 1'b0;
    end else begin
      out_valid <= st_valid;
      sl_q      <= (sl_q & ~sl_clear) | sat_event;
      if (st_valid) begin
        acc_q <= result;
        n_q   <= result[MSB];
        z_q   <= ~|result;
        c_q   <= carry;
        sv_q  <= v_add | v_rnd;
        e_q   <= out_of_32(result);
      end
    end
  end

  p_round_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st_valid && ctrl.round_en && !clip) |=> (acc_q[OP_W-1:0] == '0));

  p_sat_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st_valid && ctrl.ms) |=> ((&acc_q[MSB:TOP_LO]) || !(|acc_q[MSB:TOP_LO])));

  p_sl_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (sl_q && !sl_clear) |=> sl_q);

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !st_valid |=> $stable(acc_q));

endmodule

// File: rtl/mac40_unit.sv
module mac40_unit
  import mac40_pkg::*;
#(
  parameter int OP_W    = 16,
  parameter int GUARD_W = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         in_valid,
  input  logic [OP_W-1:0]              op_a,
  input  logic [OP_W-1:0]              op_b,
  input  logic [1:0]                   mode,
  input  logic                         negate,
  input  logic                         subtract,
  input  logic                         accumulate,
  input  logic                         round_en,
  input  logic                         mp_mode,
  input  logic                         ms_mode,
  input  logic                         sl_clear,
  output logic                         out_valid,
  output logic [2*OP_W+GUARD_W-1:0]    acc,
  output logic                         flag_n,
  output logic                         flag_z,
  output logic                         flag_c,
  output logic                         flag_sv,
  output logic                         flag_e,
  output logic                         flag_sl
);

  localparam int ACC_W = 2 * OP_W + GUARD_W;

  logic             st_valid;
  logic [ACC_W-1:0] st_prod;
  logic             st_sat;
  mac_ctrl_t        ctrl_q;

  mac40_mul #(.OP_W(OP_W), .GUARD_W(GUARD_W)) u_mul (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .op_a(op_a), .op_b(op_b), .mode(mode), .mp_mode(mp_mode), .negate(negate),
    .valid_q(st_valid), .prod_q(st_prod), .prod_sat_q(st_sat)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) ctrl_q <= '0;
    else if (in_valid) ctrl_q <= '{subtract: subtract, accumulate: accumulate,
                                   round_en: round_en, ms: ms_mode};
  end

  mac40_acc #(.OP_W(OP_W), .GUARD_W(GUARD_W)) u_acc (
    .clk(clk), .rst_n(rst_n), .st_valid(st_valid), .prod(st_prod), .prod_sat(st_sat),
    .ctrl(ctrl_q), .sl_clear(sl_clear), .out_valid(out_valid), .acc_q(acc),
    .n_q(flag_n), .z_q(flag_z), .c_q(flag_c), .sv_q(flag_sv), .e_q(flag_e), .sl_q(flag_sl)
  );

  p_latency_r9: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> ##2 out_valid);

  p_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |-> ##2 !out_valid);

endmodule

// File: tb/test_mac40_unit.sv
module test_mac40_unit;
  localparam int CLK_P = 10;
  localparam longint M40  = 64'hFF_FFFF_FFFF;
  localparam longint MAX39 = 64'sd549755813887;
  localparam longint MIN39 = -64'sd549755813888;
  localparam longint MAX31 = 64'sd2147483647;
  localparam longint MIN31 = -64'sd2147483648;

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 0, negate = 0, subtract = 0, accumulate = 0, round_en = 0;
  logic mp_mode = 0, ms_mode = 0, sl_clear = 0;
  logic [15:0] op_a = 0, op_b = 0;
  logic [1:0]  mode = 0;
  logic out_valid, flag_n, flag_z, flag_c, flag_sv, flag_e, flag_sl;
  logic [39:0] acc;

  int checks = 0, errors = 0;
  bit done = 0;
  string cur_req = "R1";

  always #(CLK_P/2) clk = ~clk;

  mac40_unit i_mac40_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_a(op_a), .op_b(op_b), .mode(mode),
    .negate(negate), .subtract(subtract), .accumulate(accumulate), .round_en(round_en),
    .mp_mode(mp_mode), .ms_mode(ms_mode), .sl_clear(sl_clear), .out_valid(out_valid),
    .acc(acc), .flag_n(flag_n), .flag_z(flag_z), .flag_c(flag_c), .flag_sv(flag_sv),
    .flag_e(flag_e), .flag_sl(flag_sl)
  );

  // reference model state
  longint m_acc = 0;
  bit m_n, m_z, m_c, m_sv, m_e, m_sl, m_ov;
  bit p_v = 0, p_neg, p_sub, p_accu, p_rnd, p_mp, p_ms;
  logic [15:0] p_a, p_b;
  logic [1:0] p_mode;

  function automatic longint sext40(longint x);
    return x[39] ? (x | ~M40) : (x & M40);
  endfunction

  task automatic model_edge();
    bit sat;
    longint pa, pb, prod, bs, exact, u, r;
    sat = 0;
    m_ov = p_v;
    if (p_v) begin
      pa = p_mode[1] ? longint'($signed(p_a)) : longint'(p_a);
      pb = p_mode[0] ? longint'($signed(p_b)) : longint'(p_b);
      prod = pa * pb;
      if (p_mode == 2'b11 && p_mp) begin
        if (pa == -32768 && pb == -32768) begin prod = MAX31; sat = 1; end
        else prod = prod * 2;
      end
      if (p_neg) prod = -prod;
      bs = p_accu ? m_acc : 0;
      exact = p_sub ? bs - prod : bs + prod;
      m_sv = (exact > MAX39) || (exact < MIN39);
      u = p_sub ? (bs & M40) + ((~prod) & M40) + 1 : (bs & M40) + (prod & M40);
      m_c = u[40];
      r = sext40(exact & M40);
      if (p_rnd) begin
        if (r + 32768 > MAX39) m_sv = 1;
        if ((((r & M40) + 32768) >> 40) != 0) m_c = 1;
        r = sext40((r + 32768) & M40);
        r = r & ~64'hFFFF;
      end
      if (p_ms && (r > MAX31 || r < MIN31)) begin
        r = (r < 0) ? MIN31 : MAX31;
        sat = 1;
      end
      m_acc = r;
      m_n = r < 0; m_z = r == 0; m_e = (r > MAX31) || (r < MIN31);
    end
    m_sl = (m_sl && !sl_clear) || sat;
    p_v = in_valid; p_a = op_a; p_b = op_b; p_mode = mode; p_neg = negate;
    p_sub = subtract; p_accu = accumulate; p_rnd = round_en; p_mp = mp_mode; p_ms = ms_mode;
  endtask

  task automatic compare();
    logic [46:0] got, exp;
    got = {out_valid, acc, flag_n, flag_z, flag_c, flag_sv, flag_e, flag_sl};
    exp = {m_ov, m_acc[39:0], m_n, m_z, m_c, m_sv, m_e, m_sl};
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got v=%b acc=%h nzcvesl=%b exp v=%b acc=%h nzcvesl=%b", cur_req,
               got[46], got[45:6], got[5:0], exp[46], exp[45:6], exp[5:0]);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare();
  endtask

  task automatic op(input logic [15:0] a, input logic [15:0] b, input logic [1:0] md,
                    input bit ng, input bit sb, input bit ac, input bit rd,
                    input bit mp, input bit ms);
    in_valid = 1; op_a = a; op_b = b; mode = md; negate = ng; subtract = sb;
    accumulate = ac; round_en = rd; mp_mode = mp; ms_mode = ms;
    tick();
    in_valid = 0;
  endtask

  task automatic idle(input int n);
    in_valid = 0;
    for (int i = 0; i < n; i++) tick();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got hung expected finish");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    cur_req = "R1"; compare();              // reset state
    cur_req = "R2";
    op(16'hFFFF, 16'hFFFF, 2'b00, 0,0,0,0,0,0);  // unsigned load
    op(16'hFFFF, 16'hFFFF, 2'b11, 0,0,1,0,0,0);  // signed: +1 accumulated
    op(16'hFFFF, 16'h0002, 2'b01, 0,0,1,0,0,0);  // a unsigned, b signed
    op(16'hFFFF, 16'h0002, 2'b10, 0,0,1,0,0,0);  // a signed, b unsigned
    idle(2);
    cur_req = "R11";
    op(16'hFFFF, 16'hFFFF, 2'b00, 0,0,0,0,0,0);  // 00_FFFE_0001: E set
    idle(2);
    cur_req = "R5";
    op(16'h0002, 16'h0003, 2'b11, 0,0,0,0,1,0);  // doubled: 12
    op(16'h0002, 16'h0003, 2'b00, 0,0,0,0,1,0);  // unsigned: 6
    op(16'hFFFE, 16'h0003, 2'b10, 0,0,1,0,1,0);  // mixed, not doubled
    idle(2);
    cur_req = "R6";
    op(16'h8000, 16'h8000, 2'b11, 0,0,0,0,1,0);
    idle(2);
    cur_req = "R8";
    sl_clear = 1; tick(); sl_clear = 0; tick();
    op(16'h8000, 16'h8000, 2'b11, 0,0,0,0,1,0);
    sl_clear = 1; tick(); sl_clear = 0;          // saturation beats clear
    tick(); sl_clear = 1; tick(); sl_clear = 0; tick();
    cur_req = "R7";
    op(16'h0010, 16'h0010, 2'b11, 0,0,0,0,0,0);
    op(16'h0003, 16'h0004, 2'b11, 1,0,1,0,0,0);  // negate
    op(16'h0003, 16'h0004, 2'b11, 0,1,1,0,0,0);  // subtract
    op(16'h0003, 16'h0004, 2'b11, 1,1,1,0,0,0);  // both: add
    idle(2);
    cur_req = "R3";
    op(16'h1234, 16'h5678, 2'b00, 0,0,0,1,0,0);
    op(16'h00FF, 16'h0080, 2'b00, 0,0,0,1,0,0);  // low half exactly 7F80
    op(16'h0001, 16'h8000, 2'b00, 0,0,0,1,0,0);  // tie 8000
    idle(2);
    cur_req = "R4";
    for (int i = 0; i < 4; i++) op(16'h7FFF, 16'h7FFF, 2'b11, 0,0,1,0,1,1);
    op(16'h8000, 16'h7FFF, 2'b11, 0,0,0,0,1,0);
    for (int i = 0; i < 4; i++) op(16'h8000, 16'h7FFF, 2'b11, 0,0,1,1,1,1);
    idle(2);
    cur_req = "R10";
    op(16'h0005, 16'h0001, 2'b00, 0,0,0,0,0,0);
    op(16'h0001, 16'h0001, 2'b00, 0,1,1,0,0,0);  // 5-1: carry out
    op(16'h0000, 16'h0000, 2'b00, 0,0,0,0,0,0);  // zero
    op(16'h0001, 16'h0001, 2'b00, 0,1,1,0,0,0);  // 0-1: negative, no carry
    for (int i = 0; i < 300; i++) op(16'h7FFF, 16'h7FFF, 2'b11, 0,0,1,0,1,0);  // 40-bit overflow
    cur_req = "R9";
    idle(5);
    op(16'h0007, 16'h0009, 2'b00, 0,0,1,0,0,0);
    idle(3);
    cur_req = "R2";
    for (int i = 0; i < 600; i++) begin
      logic [31:0] rv;
      rv = $urandom;
      sl_clear = (rv[31:28] == 4'h0);
      if (rv[27:26] == 2'b00) begin
        in_valid = 0; tick();
      end else begin
        op(16'($urandom), 16'($urandom), rv[1:0], rv[2], rv[3], rv[4] | rv[5],
           rv[6], rv[7], rv[8]);
      end
    end
    sl_clear = 0;
    idle(3);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule